// File: doc/BRIEF.md
# Dual-Phase Multiplexed Bus Link

This block moves a wide payload across a narrow set of pins by using both phases of one shared clock. The transmit side puts the lower half of the source word on the pins while the clock is high and the upper half while the clock is low. The receive side holds the high-phase half in a level-sensitive latch that closes on the falling edge. The low-phase half passes straight from the pins to the output with no storage. The two halves are joined again, so the whole word is ready to be captured at the next rising edge. The pin count is half the payload width.

The source must change its word only on the rising edge, and the destination samples the rebuilt word on the rising edge that follows. Flow-control signals are not timing-shared. The forward valid and the backward ready each run on a wire of their own between the two ends. The block models the transmit mux, the pins and the receive latch together, so a link can be checked end to end.

Top module: `dual_phase_link`

## Requirements
- R1: While the clock is high and reset is released, pin n carries source bit n, for every n below half the payload width.
- R2: While the clock is low and reset is released, pin n carries source bit n plus half the payload width.
- R3: During the low phase, the lower half of the rebuilt word keeps the value that the pins showed at the falling edge. It does not follow the pins, which by then carry the upper half.
- R4: During the low phase, the upper half of the rebuilt word equals the pins directly, with no clock edge of delay.
- R5: Just before each rising edge, the rebuilt word equals the source word launched at the previous rising edge.
- R6: The destination valid equals the source valid in both clock phases. It is never shared with data pins.
- R7: The source ready equals the destination ready in both clock phases. It is never shared with data pins.
- R8: While reset is asserted (active low), the pins, the receive latch and the rebuilt word are all zero, whatever the source word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared link clock; its level selects the half on the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_word | input | PAYLOAD_W | Source word, changed only at rising edges |
| src_valid | input | 1 | Source-side valid, forwarded on its own wire |
| src_ready | output | 1 | Ready returned to the source |
| link_pins | output | PAYLOAD_W/2 | Time-shared pin bus |
| dst_word | output | PAYLOAD_W | Rebuilt full-width word at the receiver |
| dst_valid | output | 1 | Valid seen by the destination |
| dst_ready | input | 1 | Ready driven by the destination |

## Verification
A latch that opens in the wrong phase, or that stays open, shows up in the same low phase as a lower half of dst_word equal to the upper half of the source. A swapped transmit select shows up within half a cycle as the wrong half on link_pins. Any stale latch content appears at the sample just before the next rising edge as a mismatch against the word launched one edge earlier. Every 8-bit source word is swept at a reduced width, and pins and output are checked in both phases of each cycle, so no wrong half can escape.

// File: rtl/dpl_pkg.sv
package dpl_pkg;

    // Which clock phase is driving the shared pins
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    function automatic phase_e phase_of(input logic lvl);
        return lvl ? PH_HIGH : PH_LOW;
    endfunction

endpackage

// File: rtl/dpl_tx.sv
module dpl_tx
    import dpl_pkg::*;
#(
    parameter int PAYLOAD_W = 64,
    localparam int HALF_W   = PAYLOAD_W / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PAYLOAD_W-1:0] word_i,
    output logic [HALF_W-1:0]    pins_o
);

    logic [HALF_W-1:0] low_half;
    logic [HALF_W-1:0] high_half;
    logic [HALF_W-1:0] pins_d;
    phase_e            phase;

    assign phase = phase_of(clk);

    // Pin n pairs with bit n and bit n+HALF_W
    for (genvar i = 0; i < HALF_W; i++) begin : g_pair
        assign low_half[i]  = word_i[i];
        assign high_half[i] = word_i[i + HALF_W];
    end

    always_comb begin
        pins_d = '0;
        if (rst_n) begin
            unique case (phase)
                PH_HIGH: pins_d = low_half;
                PH_LOW:  pins_d = high_half;
            endcase
        end
    end

    assign pins_o = pins_d;

endmodule

// File: rtl/dpl_rx.sv
module dpl_rx #(
    parameter int PAYLOAD_W = 64,
    localparam int HALF_W   = PAYLOAD_W / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HALF_W-1:0]    pins_i,
    output logic [PAYLOAD_W-1:0] word_o
);

    typedef struct packed {
        logic [HALF_W-1:0] held;
    } rx_state_t;

    rx_state_t lat_d, lat_q;

    // Transparent during the high phase, closed from the falling edge
    always_comb begin
        lat_d      = lat_q;
        lat_d.held = pins_i;
    end

    always_latch begin
        if (!rst_n)
            lat_q = '0;
        else if (clk)
            lat_q = lat_d;
    end

    // Upper half passes straight through from the pins
    assign word_o = {pins_i, lat_q.held};

endmodule

// File: rtl/dpl_flow.sv
module dpl_flow (
    input  logic src_valid_i,
    output logic src_ready_o,
    output logic dst_valid_o,
    input  logic dst_ready_i
);

    // Dedicated point-to-point wires, never shared with data pins
    assign dst_valid_o = src_valid_i;
    assign src_ready_o = dst_ready_i;

endmodule

// File: rtl/dual_phase_link.sv
module dual_phase_link #(
    parameter int PAYLOAD_W = 64,
    localparam int HALF_W   = PAYLOAD_W / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PAYLOAD_W-1:0] src_word,
    input  logic                 src_valid,
    output logic                 src_ready,
    output logic [HALF_W-1:0]    link_pins,
    output logic [PAYLOAD_W-1:0] dst_word,
    output logic                 dst_valid,
    input  logic                 dst_ready
);

    dpl_tx #(.PAYLOAD_W(PAYLOAD_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (src_word),
        .pins_o (link_pins)
    );

    dpl_rx #(.PAYLOAD_W(PAYLOAD_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (link_pins),
        .word_o (dst_word)
    );

    dpl_flow u_flow (
        .src_valid_i (src_valid),
        .src_ready_o (src_ready),
        .dst_valid_o (dst_valid),
        .dst_ready_i (dst_ready)
    );

endmodule

// File: rtl/dpl_checker.sv
module dpl_checker #(
    parameter int PAYLOAD_W = 64,
    localparam int HALF_W   = PAYLOAD_W / 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PAYLOAD_W-1:0] src_word,
    input logic                 src_valid,
    input logic                 src_ready,
    input logic [HALF_W-1:0]    link_pins,
    input logic [PAYLOAD_W-1:0] dst_word,
    input logic                 dst_valid,
    input logic                 dst_ready
);

    // R1
    high_phase_low_half_chk: assert property (@(negedge clk) disable iff (!rst_n)
        link_pins == src_word[HALF_W-1:0]);

    // R2
    low_phase_high_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_pins == src_word[PAYLOAD_W-1:HALF_W]);

    // R4
    upper_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_word[PAYLOAD_W-1:HALF_W] == link_pins);

    // R5
    word_rebuilt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_word == src_word);

    // R6
    valid_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid == src_valid);

    // R7
    ready_direct_chk: assert property (@(negedge clk) disable iff (!rst_n)
        src_ready == dst_ready);

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (link_pins == '0 && dst_word == '0));

endmodule

bind dual_phase_link dpl_checker #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_word  (src_word),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .link_pins (link_pins),
    .dst_word  (dst_word),
    .dst_valid (dst_valid),
    .dst_ready (dst_ready)
);

// File: tb/tb_dual_phase_link.sv
module tb_dual_phase_link;

    localparam int W = 8;
    localparam int H = W / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] src_word = '0;
    logic         src_valid = 1'b0;
    logic         src_ready;
    logic [H-1:0] link_pins;
    logic [W-1:0] dst_word;
    logic         dst_valid;
    logic         dst_ready = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_phase_link #(.PAYLOAD_W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_word  (src_word),
        .src_valid (src_valid),
        .src_ready (src_ready),
        .link_pins (link_pins),
        .dst_word  (dst_word),
        .dst_valid (dst_valid),
        .dst_ready (dst_ready)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        // R8: reset with a busy source, checked in both phases
        src_word = 8'hA5;
        @(posedge clk); #5;
        check("R8 pins high phase", W'(link_pins), '0);
        check("R8 word high phase", dst_word, '0);
        @(negedge clk); #5;
        check("R8 pins low phase", W'(link_pins), '0);
        check("R8 word low phase", dst_word, '0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        for (int w = 0; w < (1 << W); w++) begin
            logic [W-1:0] v;
            logic [H-1:0] lo;
            logic [H-1:0] hi;
            v  = W'(w);
            lo = v[H-1:0];
            hi = v[W-1:H];
            @(posedge clk); #1;
            src_word  = v;
            src_valid = v[0];
            dst_ready = v[1];
            #4;
            // high phase
            check("R1 pins carry low half", W'(link_pins), W'(lo));
            check("R6 valid high phase", W'(dst_valid), W'(v[0]));
            check("R7 ready high phase", W'(src_ready), W'(v[1]));
            @(negedge clk); #5;
            // low phase
            check("R2 pins carry high half", W'(link_pins), W'(hi));
            check("R3 lower half held", W'(dst_word[H-1:0]), W'(lo));
            check("R4 upper half direct", W'(dst_word[W-1:H]), W'(link_pins));
            check("R6 valid low phase", W'(dst_valid), W'(v[0]));
            check("R7 ready low phase", W'(src_ready), W'(v[1]));
            #4;
            check("R5 word before rising edge", dst_word, v);
        end

        // R8: reset asserted mid-run clears pins and latch
        @(posedge clk); #1;
        src_word = 8'hFF;
        #3;
        rst_n = 1'b0;
        #1;
        check("R8 pins cleared", W'(link_pins), '0);
        check("R8 latch cleared", dst_word, '0);
        @(negedge clk); #5;
        check("R8 word cleared low phase", dst_word, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule